// File: doc/BRIEF.md
# Clock fault response controller

This block decides how a chip reacts when its clocks misbehave. It watches four asynchronous fault lines: a reference-side slip and a feedback-side slip from the primary PLL, a slip from the secondary PLL, and a failure line from the oscillator monitor. Each line is synchronized and edge-detected, so one fault gives one event. The block then chooses any mix of three reactions. It can move the system clock source from the primary PLL to the oscillator, raise a flag toward the error aggregator, or send a one-cycle reset request to the reset controller.

A small four-bit register interface holds the configuration. The configuration has a two-bit bypass code, a reset-on-slip bit and a reset-on-oscillator-fail bit. The same interface exposes the slip status bits, the sticky aggregator flags and the per-channel interrupt enables. The aggregator flags sit on fixed positions of a 64-bit group vector: bit 10 for a primary slip, bit 11 for an oscillator failure and bit 42 for a secondary slip.

A soft reset returns the configuration to its defaults and clears the slip status and the clock switch-over. It does not touch the aggregator flags or the interrupt enables. Only the power-on reset clears those, apart from software clearing the flags.

Top module: `clk_fault_ctrl`

## Requirements
- R1: Each fault input passes through two synchronizer stages and a rising-edge detector. An input held high for several cycles causes exactly one event. Any reset request from that event is high for exactly one cycle, and it is seen after the third rising clock edge that follows the input's rise.
- R2: When the bypass code (address 0, bits [1:0]) equals 2'b10, a primary slip does not switch the clock, does not set aggregator bit 10 and does not request a reset, whatever the reset-on-slip bit holds.
- R3: When the bypass code is 2'b00, 2'b01 or 2'b11, a primary slip sets `clk_src_osc_o` and sets aggregator flag 0 (group bit 10).
- R4: A primary slip requests a reset only when the bypass code is not 2'b10 and the reset-on-slip bit (address 0, bit 2) is set.
- R5: Every primary slip sets its slip status bit, whatever the bypass code holds. The status register is at address 1: bit 0 for a reference slip and bit 1 for a feedback slip.
- R6: An oscillator failure sets aggregator flag 1 (group bit 11). It requests a reset only when the reset-on-oscillator-fail bit (address 0, bit 3) is set.
- R7: A secondary slip always sets aggregator flag 2 (group bit 42), under any configuration. It leaves the slip status bits unchanged.
- R8: The aggregator flags (address 2, bits [2:0]) are sticky. A soft reset does not clear them. Writing a one to a flag clears it, and so does the power-on reset.
- R9: `err_irq_o` is high exactly when some aggregator flag is set together with its enable bit (address 3, bits [2:0], in the same order as the flags). A flag whose enable bit is clear only sets its flag.
- R10: Once set, the clock switch-over stays set until the slip status register becomes all zero through software clears or a soft reset.
- R11: The status and flag registers clear when a one is written to a bit. An event that arrives in the same cycle as a clear of its bit wins, and the bit stays set.
- R12: After the power-on reset every register reads zero and every output is low. A soft reset reloads the control register with zero and clears the slip status and the switch-over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Power-on reset, synchronous, active high |
| soft_rst_i | input | 1 | Soft reset, synchronous, active high |
| pll1_ref_slip_i | input | 1 | Primary PLL reference slip, asynchronous |
| pll1_fb_slip_i | input | 1 | Primary PLL feedback slip, asynchronous |
| pll2_slip_i | input | 1 | Secondary PLL slip, asynchronous |
| osc_fail_i | input | 1 | Oscillator monitor failure, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for both read and write |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data, combinational from `reg_addr_i` |
| clk_src_osc_o | output | 1 | Request to select the oscillator as clock source 1 |
| rst_req_o | output | 1 | One-cycle reset request |
| grp1_err_o | output | 64 | Sticky aggregator flags on their channel positions |
| err_irq_o | output | 1 | Interrupt for enabled aggregator flags |

## Verification
The bench tries primary slips under all four bypass codes, with the reset-on-slip bit both set and clear. This separates the one suppressing code from the three enabling codes, and separates reset from flag-only behaviour. Secondary slips and oscillator failures are fired alone and together with primary slips, which shows that each has its own channel and that it does not touch the slip status. Soft resets and partial status clears mixed into the random sequence separate sticky flags from the state that a soft reset clears, and show when the switch-over is released. A clear timed onto the exact cycle of a new event tests the set-over-clear priority.

// File: rtl/clkfr_pkg.sv
package clkfr_pkg;

    // aggregator channel numbers inside the group vector
    localparam int GRP_W         = 64;
    localparam int CH_PLL1_SLIP  = 10;
    localparam int CH_OSC_FAIL   = 11;
    localparam int CH_PLL2_SLIP  = 42;

    // internal flag indices
    localparam int NUM_ERR  = 3;
    localparam int ERR_PLL1 = 0;
    localparam int ERR_OSC  = 1;
    localparam int ERR_PLL2 = 2;

    // slip status indices
    localparam int NUM_SLIP = 2;
    localparam int SLIP_REF = 0;
    localparam int SLIP_FB  = 1;

    // fault input indices
    localparam int NUM_FAULT_IN = 4;
    localparam int FI_REF  = 0;
    localparam int FI_FB   = 1;
    localparam int FI_PLL2 = 2;
    localparam int FI_OSC  = 3;

    typedef enum logic [1:0] {
        BYP_ON_A = 2'b00,
        BYP_ON_B = 2'b01,
        BYP_OFF  = 2'b10,
        BYP_ON_C = 2'b11
    } byp_code_e;

    typedef struct packed {
        logic      rst_on_osc;
        logic      rst_on_slip;
        byp_code_e byp;
    } ctrl_t;

    localparam int REG_AW = 2;
    localparam int REG_DW = $bits(ctrl_t);

    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_SLIP = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_ERR  = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_EN   = 2'd3;

    localparam ctrl_t CTRL_DEFAULT = '{rst_on_osc: 1'b0, rst_on_slip: 1'b0, byp: BYP_ON_A};

    typedef struct packed {
        logic                en;
        logic [REG_AW-1:0]   addr;
        logic [REG_DW-1:0]   data;
    } reg_wr_t;

    typedef struct packed {
        logic [NUM_SLIP-1:0] slip_set;
        logic [NUM_ERR-1:0]  err_set;
        logic                osc_sel_set;
    } react_t;

    function automatic logic byp_active(byp_code_e c);
        return c != BYP_OFF;
    endfunction

    function automatic int err_channel(int idx);
        case (idx)
            ERR_PLL1: return CH_PLL1_SLIP;
            ERR_OSC:  return CH_OSC_FAIL;
            default:  return CH_PLL2_SLIP;
        endcase
    endfunction

    function automatic logic [GRP_W-1:0] map_to_group(logic [NUM_ERR-1:0] f);
        logic [GRP_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_ERR; i++) begin
            v[err_channel(i)] = f[i];
        end
        return v;
    endfunction

endpackage

// File: rtl/clkfr_evsync.sv
module clkfr_evsync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] rise_o
);

    localparam int SH_W = STAGES + 1;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic [SH_W-1:0] sh_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                sh_q <= '0;
            end else begin
                sh_q <= {sh_q[SH_W-2:0], async_i[g]};
            end
        end

        assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];

        // R1
        single_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            rise_o[g] |=> !rise_o[g]);
    end

endmodule

// File: rtl/clkfr_react.sv
module clkfr_react
    import clkfr_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [NUM_FAULT_IN-1:0] ev_i,
    input  ctrl_t                   cfg_i,
    output react_t                  act_o,
    output logic                    rst_req_o
);

    logic slip_any;
    logic byp_en;
    logic req_d;
    logic rst_req_q;

    assign slip_any = ev_i[FI_REF] | ev_i[FI_FB];
    assign byp_en   = byp_active(cfg_i.byp);

    always_comb begin
        act_o                     = '0;
        act_o.slip_set[SLIP_REF]  = ev_i[FI_REF];
        act_o.slip_set[SLIP_FB]   = ev_i[FI_FB];
        act_o.err_set[ERR_PLL1]   = slip_any & byp_en;
        act_o.err_set[ERR_OSC]    = ev_i[FI_OSC];
        act_o.err_set[ERR_PLL2]   = ev_i[FI_PLL2];
        act_o.osc_sel_set         = slip_any & byp_en;
        req_d = (slip_any & byp_en & cfg_i.rst_on_slip)
              | (ev_i[FI_OSC] & cfg_i.rst_on_osc);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= req_d;
        end
    end

    assign rst_req_o = rst_req_q;

    // R2
    bypass_off_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (slip_any && cfg_i.byp == BYP_OFF && !ev_i[FI_OSC]) |=> !rst_req_o);

    // R4
    slip_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (slip_any && cfg_i.byp != BYP_OFF && cfg_i.rst_on_slip) |=> rst_req_o);

    // R6
    osc_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_i[FI_OSC] && cfg_i.rst_on_osc) |=> rst_req_o);

endmodule

// File: rtl/clkfr_regs.sv
module clkfr_regs
    import clkfr_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                soft_rst_i,
    input  reg_wr_t             wr_i,
    input  logic [REG_AW-1:0]   rd_addr_i,
    input  logic [NUM_SLIP-1:0] slip_set_i,
    input  logic                osc_sel_set_i,
    input  logic [NUM_ERR-1:0]  err_flags_i,
    output ctrl_t               cfg_o,
    output logic [NUM_ERR-1:0]  irq_en_o,
    output logic [NUM_ERR-1:0]  err_clr_o,
    output logic                osc_sel_o,
    output logic [REG_DW-1:0]   rdata_o
);

    ctrl_t               ctrl_q;
    logic [NUM_SLIP-1:0] status_q, status_d, status_clr;
    logic                osc_sel_q, osc_sel_d;
    logic [NUM_ERR-1:0]  en_q;
    logic                wr_slip;

    assign wr_slip    = wr_i.en && wr_i.addr == ADDR_SLIP;
    assign status_clr = wr_slip ? wr_i.data[NUM_SLIP-1:0] : '0;
    assign err_clr_o  = (wr_i.en && wr_i.addr == ADDR_ERR) ? wr_i.data[NUM_ERR-1:0] : '0;

    always_comb begin
        if (soft_rst_i) begin
            status_d  = '0;
            osc_sel_d = 1'b0;
        end else begin
            status_d = (status_q & ~status_clr) | slip_set_i;
            if (osc_sel_set_i) begin
                osc_sel_d = 1'b1;
            end else if (status_d == '0) begin
                osc_sel_d = 1'b0;
            end else begin
                osc_sel_d = osc_sel_q;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q    <= CTRL_DEFAULT;
            status_q  <= '0;
            osc_sel_q <= 1'b0;
            en_q      <= '0;
        end else begin
            status_q  <= status_d;
            osc_sel_q <= osc_sel_d;
            if (soft_rst_i) begin
                ctrl_q <= CTRL_DEFAULT;
            end else if (wr_i.en && wr_i.addr == ADDR_CTRL) begin
                ctrl_q <= ctrl_t'(wr_i.data);
            end
            if (wr_i.en && wr_i.addr == ADDR_EN) begin
                en_q <= wr_i.data[NUM_ERR-1:0];
            end
        end
    end

    always_comb begin
        case (rd_addr_i)
            ADDR_CTRL: rdata_o = REG_DW'(ctrl_q);
            ADDR_SLIP: rdata_o = REG_DW'(status_q);
            ADDR_ERR:  rdata_o = REG_DW'(err_flags_i);
            default:   rdata_o = REG_DW'(en_q);
        endcase
    end

    assign cfg_o     = ctrl_q;
    assign irq_en_o  = en_q;
    assign osc_sel_o = osc_sel_q;

    // R5
    slip_status_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (slip_set_i[SLIP_REF] && !soft_rst_i) |=> status_q[SLIP_REF]);

    // R10
    osc_sel_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (osc_sel_q && !soft_rst_i && !wr_slip) |=> osc_sel_q);

    // R12
    soft_rst_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        soft_rst_i |=> (status_q == '0 && !osc_sel_q && ctrl_q == CTRL_DEFAULT));

endmodule

// File: rtl/clkfr_errflags.sv
module clkfr_errflags
    import clkfr_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_ERR-1:0] err_set_i,
    input  logic [NUM_ERR-1:0] err_clr_i,
    input  logic [NUM_ERR-1:0] irq_en_i,
    output logic [NUM_ERR-1:0] flags_o,
    output logic [GRP_W-1:0]   grp_o,
    output logic               irq_o
);

    logic [NUM_ERR-1:0] flags_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~err_clr_i) | err_set_i;
        end
    end

    assign flags_o = flags_q;
    assign grp_o   = map_to_group(flags_q);
    assign irq_o   = |(flags_q & irq_en_i);

    for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
        // R8
        sticky_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (flags_q[i] && !err_clr_i[i]) |=> flags_q[i]);

        // R11
        set_over_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (err_set_i[i] && err_clr_i[i]) |=> flags_q[i]);
    end

    // R7
    pll2_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        err_set_i[ERR_PLL2] |=> grp_o[CH_PLL2_SLIP]);

endmodule

// File: rtl/clk_fault_ctrl.sv
module clk_fault_ctrl
    import clkfr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              soft_rst_i,
    input  logic              pll1_ref_slip_i,
    input  logic              pll1_fb_slip_i,
    input  logic              pll2_slip_i,
    input  logic              osc_fail_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic              clk_src_osc_o,
    output logic              rst_req_o,
    output logic [GRP_W-1:0]  grp1_err_o,
    output logic              err_irq_o
);

    logic [NUM_FAULT_IN-1:0] raw_fault;
    logic [NUM_FAULT_IN-1:0] fault_ev;
    reg_wr_t                 wr;
    ctrl_t                   cfg;
    react_t                  act;
    logic [NUM_ERR-1:0]      flags;
    logic [NUM_ERR-1:0]      irq_en;
    logic [NUM_ERR-1:0]      err_clr;

    assign raw_fault[FI_REF]  = pll1_ref_slip_i;
    assign raw_fault[FI_FB]   = pll1_fb_slip_i;
    assign raw_fault[FI_PLL2] = pll2_slip_i;
    assign raw_fault[FI_OSC]  = osc_fail_i;

    assign wr = '{en: reg_wr_i, addr: reg_addr_i, data: reg_wdata_i};

    clkfr_evsync #(.N(NUM_FAULT_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (raw_fault),
        .rise_o  (fault_ev)
    );

    clkfr_react u_react (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ev_i      (fault_ev),
        .cfg_i     (cfg),
        .act_o     (act),
        .rst_req_o (rst_req_o)
    );

    clkfr_regs u_regs (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .soft_rst_i    (soft_rst_i),
        .wr_i          (wr),
        .rd_addr_i     (reg_addr_i),
        .slip_set_i    (act.slip_set),
        .osc_sel_set_i (act.osc_sel_set),
        .err_flags_i   (flags),
        .cfg_o         (cfg),
        .irq_en_o      (irq_en),
        .err_clr_o     (err_clr),
        .osc_sel_o     (clk_src_osc_o),
        .rdata_o       (reg_rdata_o)
    );

    clkfr_errflags u_err (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .err_set_i (act.err_set),
        .err_clr_i (err_clr),
        .irq_en_i  (irq_en),
        .flags_o   (flags),
        .grp_o     (grp1_err_o),
        .irq_o     (err_irq_o)
    );

    // R3
    switch_on_slip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (act.osc_sel_set && !soft_rst_i) |=> (clk_src_osc_o && grp1_err_o[CH_PLL1_SLIP]));

    // R9
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (grp1_err_o == '0) |-> !err_irq_o);

endmodule

// File: tb/tb_clk_fault_ctrl.sv
module tb_clk_fault_ctrl;

    logic        clk = 1'b0;
    logic        rst_i, soft_rst_i;
    logic        rf_i, fb_i, p2_i, osc_i;
    logic        reg_wr_i;
    logic [1:0]  reg_addr_i;
    logic [3:0]  reg_wdata_i;
    logic [3:0]  reg_rdata_o;
    logic        clk_src_osc_o, rst_req_o, err_irq_o;
    logic [63:0] grp1_err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    logic [3:0] m_ctrl;
    logic [1:0] m_status;
    logic       m_osc;
    logic [2:0] m_flags;
    logic [2:0] m_en;

    always #10 clk = ~clk;

    clk_fault_ctrl dut (
        .clk_i(clk), .rst_i(rst_i), .soft_rst_i(soft_rst_i),
        .pll1_ref_slip_i(rf_i), .pll1_fb_slip_i(fb_i),
        .pll2_slip_i(p2_i), .osc_fail_i(osc_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .clk_src_osc_o(clk_src_osc_o), .rst_req_o(rst_req_o),
        .grp1_err_o(grp1_err_o), .err_irq_o(err_irq_o)
    );

    function automatic logic [63:0] exp_grp(logic [2:0] f);
        logic [63:0] v = '0;
        v[10] = f[0];
        v[11] = f[1];
        v[42] = f[2];
        return v;
    endfunction

    function automatic int exp_pulses(logic [3:0] c, logic rf, logic fb, logic osc);
        logic en = (c[1:0] != 2'b10);
        return (((rf | fb) & en & c[2]) | (osc & c[3])) ? 1 : 0;
    endfunction

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [3:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [3:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic fire(logic rf, logic fb, logic p2, logic osc, output int pulses);
        pulses = 0;
        @(negedge clk);
        rf_i = rf; fb_i = fb; p2_i = p2; osc_i = osc;
        for (int c = 0; c < 9; c++) begin
            @(negedge clk);
            if (rst_req_o) pulses++;
            if (c == 4) begin rf_i = 0; fb_i = 0; p2_i = 0; osc_i = 0; end
        end
    endtask

    task automatic model_event(logic rf, logic fb, logic p2, logic osc);
        m_status |= {fb, rf};
        if ((rf | fb) && m_ctrl[1:0] != 2'b10) begin m_flags[0] = 1; m_osc = 1; end
        if (osc) m_flags[1] = 1;
        if (p2)  m_flags[2] = 1;
    endtask

    task automatic check_all(string req);
        logic [3:0] d;
        rd(2'd0, d); chk(req, "ctrl", d, m_ctrl);
        rd(2'd1, d); chk(req, "slip status", d, m_status);
        rd(2'd2, d); chk(req, "err flags", d, m_flags);
        rd(2'd3, d); chk(req, "irq enables", d, m_en);
        chk(req, "group vector", grp1_err_o, exp_grp(m_flags));
        chk(req, "clock source", clk_src_osc_o, m_osc);
        chk(req, "irq", err_irq_o, |(m_flags & m_en));
    endtask

    task automatic do_fire(string req, logic rf, logic fb, logic p2, logic osc);
        int p;
        fire(rf, fb, p2, osc, p);
        chk(req, "reset pulses", p, exp_pulses(m_ctrl, rf, fb, osc));
        model_event(rf, fb, p2, osc);
        check_all(req);
    endtask

    task automatic do_soft();
        @(negedge clk); soft_rst_i = 1;
        @(negedge clk); soft_rst_i = 0;
        m_ctrl = 0; m_status = 0; m_osc = 0;
    endtask

    task automatic clr_status(logic [1:0] d);
        wr(2'd1, {2'b0, d});
        m_status &= ~d;
        if (m_status == 0) m_osc = 0;
    endtask

    task automatic model_por();
        m_ctrl = 0; m_status = 0; m_osc = 0; m_flags = 0; m_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int p;
        logic [3:0] d;
        void'($urandom(32'd20240611));
        rst_i = 1; soft_rst_i = 0; rf_i = 0; fb_i = 0; p2_i = 0; osc_i = 0;
        reg_wr_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
        repeat (3) @(negedge clk);
        rst_i = 0;
        model_por();
        // R12 reset state
        check_all("R12");
        chk("R12", "reset request", rst_req_o, 0);

        // R1 latency and single pulse
        wr(2'd0, 4'b1000); m_ctrl = 4'b1000;
        @(negedge clk); osc_i = 1;
        @(negedge clk); chk("R1", "req after 1 edge", rst_req_o, 0);
        @(negedge clk); chk("R1", "req after 2 edges", rst_req_o, 0);
        @(negedge clk); chk("R1", "req after 3 edges", rst_req_o, 1);
        @(negedge clk); chk("R1", "req after 4 edges", rst_req_o, 0);
        repeat (6) @(negedge clk);
        chk("R1", "held input pulses", rst_req_o, 0);
        osc_i = 0; repeat (4) @(negedge clk);
        m_flags[1] = 1;
        check_all("R1");

        // R2 bypass off suppresses everything but status
        wr(2'd0, 4'b0110); m_ctrl = 4'b0110;
        do_fire("R2", 1, 0, 0, 0);
        do_fire("R2", 1, 1, 0, 0);

        // R3 R4 enabled code with reset-on-slip
        wr(2'd0, 4'b0101); m_ctrl = 4'b0101;
        do_fire("R3", 0, 1, 0, 0);
        chk("R4", "switch on slip", clk_src_osc_o, 1);

        // R10 partial clear keeps switch, full clear releases
        clr_status(2'b01); check_all("R10");
        chk("R10", "latched after partial clear", clk_src_osc_o, 1);
        clr_status(2'b10); check_all("R10");

        // R5 status independent of code 11 without reset bit
        wr(2'd0, 4'b0011); m_ctrl = 4'b0011;
        do_fire("R5", 1, 0, 0, 0);

        // R7 secondary slip with bypass off
        wr(2'd0, 4'b0110); m_ctrl = 4'b0110;
        clr_status(2'b11);
        do_fire("R7", 0, 0, 1, 0);

        // R6 oscillator fail with and without reset bit
        wr(2'd2, 4'b0010); m_flags[1] = 0;
        do_fire("R6", 0, 0, 0, 1);
        wr(2'd0, 4'b1000); m_ctrl = 4'b1000;
        do_fire("R6", 0, 0, 0, 1);

        // R9 enables
        wr(2'd3, 4'b0100); m_en = 3'b100; check_all("R9");
        wr(2'd2, 4'b0100); m_flags[2] = 0; check_all("R9");

        // R8 soft reset keeps flags, W1C clears
        wr(2'd0, 4'b0001); m_ctrl = 4'b0001;
        do_fire("R8", 1, 0, 1, 0);
        do_soft(); check_all("R8");
        wr(2'd2, 4'b0001); m_flags[0] = 0; check_all("R8");

        // R11 clear coincident with new event
        wr(2'd0, 4'b0000); m_ctrl = 0;
        do_fire("R11", 1, 0, 0, 0);
        @(negedge clk); rf_i = 1;
        @(negedge clk);
        @(negedge clk); reg_wr_i = 1; reg_addr_i = 2'd2; reg_wdata_i = 4'b0001;
        @(negedge clk); reg_wr_i = 0;
        rd(2'd2, d); chk("R11", "flag after set and clear", d[0], 1);
        rf_i = 0; repeat (4) @(negedge clk);
        check_all("R11");
        wr(2'd2, 4'b0001); m_flags[0] = 0; check_all("R11");

        // random mix
        for (int it = 0; it < 80; it++) begin
            int sel = $urandom % 10;
            logic [3:0] ev = 4'($urandom);
            if (sel < 2) begin
                logic [3:0] c = 4'($urandom);
                wr(2'd0, c); m_ctrl = c;
            end else if (sel == 2) begin
                logic [1:0] c = 2'($urandom);
                clr_status(c);
            end else if (sel == 3) begin
                logic [2:0] c = 3'($urandom);
                wr(2'd2, {1'b0, c}); m_flags &= ~c;
            end else if (sel == 4) begin
                logic [2:0] c = 3'($urandom);
                wr(2'd3, {1'b0, c}); m_en = c;
            end else if (sel == 5) begin
                do_soft();
            end
            if (ev == 0) ev = 4'b0001;
            do_fire("R3", ev[0], ev[1], ev[2], ev[3]);
        end

        // R8 power-on reset clears flags
        @(negedge clk); rst_i = 1;
        @(negedge clk); rst_i = 0;
        model_por(); check_all("R8");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule